// File: doc/BRIEF.md
# Disk Controller Command-Phase Sequencer

This block is the byte-wide host side of a floppy-style disk controller. The host sees two things: a status byte that tells it whether the controller will take a byte, has a byte ready, or is busy, and a single data port through which command bytes, parameter bytes, sector data and result bytes all pass. Each recognised opcode has a fixed parameter count and a fixed result count. The sequencer accepts the opcode and its parameters, runs an execution phase, and then hands the result bytes back one at a time.

Two opcodes are recognised. A sector read (0xE6) streams sector data to the host through the data port without DMA. The data comes from a built-in byte source that stands in for the medium and whose track length is a parameter. A read-ID (0x0A) waits for a fixed delay and then reports the present head position. Any other opcode produces a single invalid-command status byte. An interrupt line marks the result phase of the two real commands.

Top module: `fdc_host_seq`

## Requirements
- R1: The status byte uses bit 7 for request, bit 6 for direction (1 = controller to host), bit 5 for non-DMA execution and bit 4 for busy. It reads 0x80 while waiting for an opcode, 0x90 while taking parameters, 0x10 during the read-ID wait, 0xF0 during the read data phase and 0xD0 during the result phase.
- R2: A write strobe is accepted only when request is set and direction is clear. Any other write changes neither the status byte nor the byte presented on the data port.
- R3: A read strobe advances the sequencer only when request and direction are both set. A read in the command or parameter phase has no effect.
- R4: Opcode 0xE6 takes exactly 8 parameter bytes in this order: select (bit 2 head, bits 1:0 drive), cylinder, head, start sector, size code, end sector, gap and data length. The interrupt stays low throughout.
- R5: The read data phase transfers sectors from the start sector through the last sector, where the last sector is min(end sector, SECTORS_PER_TRACK). Each sector holds UNIT_BYTES × max(size code, 1) bytes. Byte k of sector s reads (s + k) mod 256.
- R6: After a read, 7 result bytes follow: status 0, 0x00, 0x00, cylinder, head, last sector and size code. Status 0 is 0x04 when the end sector lies within the track.
- R7: When the end sector exceeds SECTORS_PER_TRACK, the transfer stops at the track's last sector and status 0 is 0x20. When the start sector lies beyond the last sector, no data is transferred and the result phase begins at once.
- R8: The interrupt rises when the result phase of a read or read-ID begins and stays high until the final result byte is read. It then falls as the status byte returns to 0x80.
- R9: Opcode 0x0A takes one select byte. It then holds status 0x10 for ID_DELAY cycles and returns 7 bytes: select bits 2:0 as status 0, 0x00, 0x00, the present cylinder (the cylinder of the most recent read, 0 after reset), the head bit, 0x01 and 0x02.
- R10: Any other opcode gives one result byte 0x80 with the interrupt kept low. The sequencer then returns to status 0x80.
- R11: After reset the status byte is 0x80, the interrupt is low and the data port reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle host write strobe for the data port |
| wr_data | input | 8 | Byte written by the host |
| rd_stb | input | 1 | One-cycle host read strobe for the data port; the byte shown on rd_data is consumed |
| rd_data | output | 8 | Byte currently offered on the data port |
| status | output | 8 | Handshake status byte |
| irq | output | 1 | Interrupt request for the result phase |

## Verification
The bench builds the block with UNIT_BYTES = 4, SECTORS_PER_TRACK = 6 and ID_DELAY = 5. The small sector size keeps multi-sector transfers with both size codes 1 and 2 to a few dozen reads, so every data byte can be compared against its expected value. The six-sector track makes an end-of-track overrun and an empty transfer cheap to provoke. The short read-ID delay lets the bench check the busy-only status on the exact cycle before it ends.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

    typedef enum logic [2:0] {
        PH_CMD     = 3'd0,
        PH_PARAM   = 3'd1,
        PH_EXEC_ID = 3'd2,
        PH_DATA    = 3'd3,
        PH_RESULT  = 3'd4
    } phase_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_READ = 2'd1,
        OP_RDID = 2'd2,
        OP_BAD  = 2'd3
    } op_t;

    localparam logic [7:0] OPC_READ = 8'hE6;
    localparam logic [7:0] OPC_RDID = 8'h0A;

    localparam logic [3:0] NPAR_READ = 4'd8;
    localparam logic [3:0] NPAR_RDID = 4'd1;
    localparam logic [2:0] NRES_FULL = 3'd7;
    localparam logic [2:0] NRES_BAD  = 3'd1;

    localparam logic [7:0] STAT_IDLE   = 8'h80;
    localparam logic [7:0] STAT_PARAM  = 8'h90;
    localparam logic [7:0] STAT_IDWAIT = 8'h10;
    localparam logic [7:0] STAT_DATA   = 8'hF0;
    localparam logic [7:0] STAT_RESULT = 8'hD0;

    localparam int BIT_REQ = 7;
    localparam int BIT_DIR = 6;

    localparam logic [7:0] ST0_NORMAL  = 8'h04;
    localparam logic [7:0] ST0_PASTEOT = 8'h20;
    localparam logic [7:0] ST0_INVALID = 8'h80;

    typedef struct packed {
        phase_t     phase;
        op_t        op;
        logic [3:0] np;
        logic [3:0] pidx;
        logic [7:0] sel;
        logic [7:0] cyl;
        logic [7:0] head;
        logic [7:0] sec;
        logic [7:0] size;
        logic [7:0] eot;
        logic [7:0] st0;
        logic [7:0] pcyl;
        logic [2:0] ridx;
        logic       irq;
    } seq_t;

    localparam seq_t SEQ_RESET = seq_t'(0);

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
    import fdc_seq_pkg::*;
(
    input  logic [7:0] opcode,
    output op_t        op,
    output logic [3:0] nparams
);
    always_comb begin
        case (opcode)
            OPC_READ: begin op = OP_READ; nparams = NPAR_READ; end
            OPC_RDID: begin op = OP_RDID; nparams = NPAR_RDID; end
            default:  begin op = OP_BAD;  nparams = 4'd0;      end
        endcase
    end
endmodule

// File: rtl/fdc_xfer_ctr.sv
module fdc_xfer_ctr #(
    parameter int OFFW = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [OFFW-1:0] bps,
    input  logic [7:0]      first_sec,
    input  logic [7:0]      last_sec,
    input  logic            take,
    output logic [7:0]      byte_o,
    output logic            last_o
);
    logic [OFFW-1:0] off_d, off_q;
    logic [OFFW-1:0] bps_d, bps_q;
    logic [7:0]      sec_d, sec_q;
    logic [7:0]      end_d, end_q;
    logic            sec_end;

    assign sec_end = (off_q == bps_q - OFFW'(1));
    assign byte_o  = sec_q + off_q[7:0];
    assign last_o  = sec_end && (sec_q == end_q);

    always_comb begin
        off_d = off_q;
        bps_d = bps_q;
        sec_d = sec_q;
        end_d = end_q;
        if (load) begin
            off_d = '0;
            bps_d = bps;
            sec_d = first_sec;
            end_d = last_sec;
        end else if (take) begin
            if (sec_end) begin
                off_d = '0;
                sec_d = sec_q + 8'd1;
            end else begin
                off_d = off_q + OFFW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
            bps_q <= '0;
            sec_q <= '0;
            end_q <= '0;
        end else begin
            off_q <= off_d;
            bps_q <= bps_d;
            sec_q <= sec_d;
            end_q <= end_d;
        end
    end
endmodule

// File: rtl/fdc_result_mux.sv
module fdc_result_mux
    import fdc_seq_pkg::*;
(
    input  op_t        op,
    input  logic [2:0] ridx,
    input  logic [7:0] st0,
    input  logic [7:0] cyl,
    input  logic [7:0] head,
    input  logic [7:0] last_sec,
    input  logic [7:0] size,
    input  logic [7:0] pcyl,
    input  logic       id_head,
    output logic [7:0] res_byte
);
    always_comb begin
        res_byte = 8'h00;
        if (ridx == 3'd0) begin
            res_byte = st0;
        end else if (op == OP_READ) begin
            case (ridx)
                3'd3:    res_byte = cyl;
                3'd4:    res_byte = head;
                3'd5:    res_byte = last_sec;
                3'd6:    res_byte = size;
                default: res_byte = 8'h00;
            endcase
        end else if (op == OP_RDID) begin
            case (ridx)
                3'd3:    res_byte = pcyl;
                3'd4:    res_byte = {7'd0, id_head};
                3'd5:    res_byte = 8'd1;
                3'd6:    res_byte = 8'd2;
                default: res_byte = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/fdc_host_seq.sv
module fdc_host_seq
    import fdc_seq_pkg::*;
#(
    parameter int UNIT_BYTES        = 512,
    parameter int SECTORS_PER_TRACK = 18,
    parameter int ID_DELAY          = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic       rd_stb,
    output logic [7:0] rd_data,
    output logic [7:0] status,
    output logic       irq
);
    localparam int OFFW = $clog2(UNIT_BYTES) + 8;
    localparam int DLYW = $clog2(ID_DELAY + 1);
    localparam logic [7:0]      SPT8    = 8'(SECTORS_PER_TRACK);
    localparam logic [DLYW-1:0] DLY_END = DLYW'(ID_DELAY - 1);

    seq_t s_d, s_q;
    logic [DLYW-1:0] dly_d, dly_q;

    op_t        dec_op;
    logic [3:0] dec_np;
    logic       wr_ok, rd_ok;
    logic       past_eot;
    logic [7:0] last_sec, factor;
    logic [OFFW-1:0] bps;
    logic       ctr_load, ctr_take, ctr_last;
    logic [7:0] ctr_byte, res_byte;
    logic [2:0] res_n;

    always_comb begin
        case (s_q.phase)
            PH_CMD:     status = STAT_IDLE;
            PH_PARAM:   status = STAT_PARAM;
            PH_EXEC_ID: status = STAT_IDWAIT;
            PH_DATA:    status = STAT_DATA;
            PH_RESULT:  status = STAT_RESULT;
            default:    status = STAT_IDLE;
        endcase
    end

    assign wr_ok    = wr_stb && status[BIT_REQ] && !status[BIT_DIR];
    assign rd_ok    = rd_stb && status[BIT_REQ] && status[BIT_DIR];
    assign past_eot = (s_q.eot > SPT8);
    assign last_sec = past_eot ? SPT8 : s_q.eot;
    assign factor   = (s_q.size == 8'd0) ? 8'd1 : s_q.size;
    assign bps      = OFFW'(UNIT_BYTES) * OFFW'(factor);
    assign ctr_take = rd_ok && (s_q.phase == PH_DATA);
    assign res_n    = (s_q.op == OP_BAD) ? NRES_BAD : NRES_FULL;
    assign irq      = s_q.irq;

    fdc_cmd_decode u_dec (
        .opcode  (wr_data),
        .op      (dec_op),
        .nparams (dec_np)
    );

    fdc_xfer_ctr #(.OFFW(OFFW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctr_load),
        .bps       (bps),
        .first_sec (s_q.sec),
        .last_sec  (last_sec),
        .take      (ctr_take),
        .byte_o    (ctr_byte),
        .last_o    (ctr_last)
    );

    fdc_result_mux u_res (
        .op       (s_q.op),
        .ridx     (s_q.ridx),
        .st0      (s_q.st0),
        .cyl      (s_q.cyl),
        .head     (s_q.head),
        .last_sec (last_sec),
        .size     (s_q.size),
        .pcyl     (s_q.pcyl),
        .id_head  (s_q.sel[2]),
        .res_byte (res_byte)
    );

    always_comb begin
        case (s_q.phase)
            PH_DATA:   rd_data = ctr_byte;
            PH_RESULT: rd_data = res_byte;
            default:   rd_data = 8'h00;
        endcase
    end

    always_comb begin
        s_d      = s_q;
        dly_d    = dly_q;
        ctr_load = 1'b0;
        case (s_q.phase)
            PH_CMD: begin
                if (wr_ok) begin
                    s_d.op   = dec_op;
                    s_d.ridx = 3'd0;
                    if (dec_op == OP_BAD) begin
                        s_d.st0   = ST0_INVALID;
                        s_d.phase = PH_RESULT;
                    end else begin
                        s_d.np    = dec_np;
                        s_d.pidx  = 4'd0;
                        s_d.phase = PH_PARAM;
                    end
                end
            end
            PH_PARAM: begin
                if (wr_ok) begin
                    s_d.pidx = s_q.pidx + 4'd1;
                    case (s_q.pidx)
                        4'd0:    s_d.sel  = wr_data;
                        4'd1:    s_d.cyl  = wr_data;
                        4'd2:    s_d.head = wr_data;
                        4'd3:    s_d.sec  = wr_data;
                        4'd4:    s_d.size = wr_data;
                        4'd5:    s_d.eot  = wr_data;
                        default: ;
                    endcase
                    if (s_q.pidx == s_q.np - 4'd1) begin
                        if (s_q.op == OP_RDID) begin
                            dly_d     = '0;
                            s_d.phase = PH_EXEC_ID;
                        end else begin
                            s_d.pcyl = s_q.cyl;
                            s_d.st0  = past_eot ? ST0_PASTEOT : ST0_NORMAL;
                            if (s_q.sec > last_sec) begin
                                s_d.irq   = 1'b1;
                                s_d.phase = PH_RESULT;
                            end else begin
                                ctr_load  = 1'b1;
                                s_d.phase = PH_DATA;
                            end
                        end
                    end
                end
            end
            PH_EXEC_ID: begin
                if (dly_q == DLY_END) begin
                    s_d.st0   = {5'd0, s_q.sel[2:0]};
                    s_d.irq   = 1'b1;
                    s_d.ridx  = 3'd0;
                    s_d.phase = PH_RESULT;
                end else begin
                    dly_d = dly_q + DLYW'(1);
                end
            end
            PH_DATA: begin
                if (rd_ok && ctr_last) begin
                    s_d.irq   = 1'b1;
                    s_d.ridx  = 3'd0;
                    s_d.phase = PH_RESULT;
                end
            end
            PH_RESULT: begin
                if (rd_ok) begin
                    if (s_q.ridx == res_n - 3'd1) begin
                        s_d.irq   = 1'b0;
                        s_d.op    = OP_NONE;
                        s_d.phase = PH_CMD;
                    end else begin
                        s_d.ridx = s_q.ridx + 3'd1;
                    end
                end
            end
            default: s_d.phase = PH_CMD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q   <= SEQ_RESET;
            dly_q <= '0;
        end else begin
            s_q   <= s_d;
            dly_q <= dly_d;
        end
    end
endmodule

// File: rtl/fdc_host_seq_chk.sv
module fdc_host_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic       rd_stb,
    input logic [7:0] rd_data,
    input logic [7:0] status,
    input logic       irq
);
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        status inside {8'h80, 8'h90, 8'h10, 8'hF0, 8'hD0}); // R1

    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !rd_stb && status[6]) |=> ($stable(status) && $stable(rd_data))); // R2

    AST_RD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && status == 8'h80) |=> (status == 8'h80)); // R3

    AST_PARAM_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'h90) |-> !irq); // R4

    AST_IRQ_IN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status == 8'hD0)); // R8

    AST_IRQ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> (status == 8'h80)); // R8
endmodule

bind fdc_host_seq fdc_host_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .rd_stb  (rd_stb),
    .rd_data (rd_data),
    .status  (status),
    .irq     (irq)
);

// File: tb/tb_fdc_host_seq.sv
module tb_fdc_host_seq;
    localparam int UB  = 4;
    localparam int SPT = 6;
    localparam int IDD = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data, status;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] mon_val = 8'h00;
    logic       mon_vld = 1'b0;
    logic [7:0] pcyl_model = 8'h00;

    always #10 clk = ~clk;

    fdc_host_seq #(.UNIT_BYTES(UB), .SECTORS_PER_TRACK(SPT), .ID_DELAY(IDD)) dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_data(rd_data), .status(status), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    // scoreboard monitor: compares each consumed byte with the queued expectation
    always @(posedge clk) begin
        if (mon_vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard underflow", mon_val, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(mon_val == e, t, mon_val, e);
            end
        end
    end

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_stb = 1'b1; wr_data = v;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] v, input string tag);
        exp_q.push_back(v); tag_q.push_back(tag);
        @(negedge clk); mon_val = rd_data; mon_vld = 1'b1; rd_stb = 1'b1;
        @(negedge clk); mon_vld = 1'b0; rd_stb = 1'b0;
    endtask

    task automatic rd_raw();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic stat_is(input logic [7:0] s, input logic i, input string tag);
        chk(status == s, tag, status, s);
        chk(irq == i, {tag, " irq"}, irq, i);
    endtask

    task automatic results(input logic [7:0] r[7], input string tag);
        for (int i = 0; i < 7; i++) begin
            if (i == 6) chk(irq == 1'b1, "R8 irq before final byte", irq, 1);
            rd_expect(r[i], tag);
        end
        stat_is(8'h80, 1'b0, "R8 back to command phase");
    endtask

    // sector read; poke=1 adds an ignored write in the data phase
    task automatic do_read(input logic [7:0] sel, cyl, head, sec, size, eot, input bit poke);
        automatic logic [7:0] lastsec = (eot > SPT) ? 8'(SPT) : eot;
        automatic int bps = UB * ((size == 0) ? 1 : size);
        automatic logic [7:0] p[8] = '{sel, cyl, head, sec, size, eot, 8'h1B, 8'hFF};
        automatic int nrd = 0;
        automatic logic [7:0] r[7];
        wr(8'hE6);
        stat_is(8'h90, 1'b0, "R4 after opcode");
        rd_raw();
        chk(status == 8'h90, "R3 read in parameter phase", status, 8'h90);
        for (int i = 0; i < 8; i++) begin
            wr(p[i]);
            if (i < 7) stat_is(8'h90, 1'b0, "R4 parameter phase");
        end
        pcyl_model = cyl;
        if (sec > lastsec) begin
            stat_is(8'hD0, 1'b1, "R7 empty transfer goes to result");
        end else begin
            stat_is(8'hF0, 1'b0, "R1 data phase status");
            for (int s = sec; s <= lastsec; s++) begin
                for (int k = 0; k < bps; k++) begin
                    rd_expect(8'(s + k), "R5 data byte");
                    nrd++;
                    if (poke && nrd == 3) begin
                        wr(8'hAA);
                        chk(status == 8'hF0, "R2 write in data phase", status, 8'hF0);
                    end
                end
            end
            stat_is(8'hD0, 1'b1, "R8 result phase entered");
        end
        r = '{(eot > SPT) ? 8'h20 : 8'h04, 8'h00, 8'h00, cyl, head, lastsec, size};
        results(r, (eot > SPT) ? "R7 result byte" : "R6 result byte");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        logic [7:0] r[7];
        repeat (3) @(negedge clk);
        stat_is(8'h80, 1'b0, "R11 reset status");
        chk(rd_data == 8'h00, "R11 reset data", rd_data, 0);
        @(negedge clk); rst_n = 1'b1;

        // R3: read strobe in command phase is ignored
        rd_raw();
        stat_is(8'h80, 1'b0, "R3 read in command phase");

        // R5/R6: two sectors of size 2 inside the track, with an ignored write
        do_read(8'h00, 8'd3, 8'd0, 8'd1, 8'd2, 8'd2, 1'b1);

        // R7: end sector past the track end
        do_read(8'h04, 8'd9, 8'd1, 8'd5, 8'd1, 8'd7, 1'b0);

        // R9: read-ID reports the present cylinder
        wr(8'h0A);
        stat_is(8'h90, 1'b0, "R9 parameter phase");
        wr(8'h05);
        stat_is(8'h10, 1'b0, "R9 busy wait starts");
        repeat (IDD - 1) @(negedge clk);
        stat_is(8'h10, 1'b0, "R9 busy wait last cycle");
        @(negedge clk);
        stat_is(8'hD0, 1'b1, "R9 result phase");
        r = '{8'h05, 8'h00, 8'h00, pcyl_model, 8'h01, 8'h01, 8'h02};
        results(r, "R9 result byte");

        // R10: unknown opcode, plus an ignored write in its result phase
        wr(8'h55);
        stat_is(8'hD0, 1'b0, "R10 invalid result phase");
        wr(8'h0A);
        chk(status == 8'hD0, "R2 write in result phase", status, 8'hD0);
        chk(rd_data == 8'h80, "R2 data unchanged after write", rd_data, 8'h80);
        rd_expect(8'h80, "R10 invalid status byte");
        stat_is(8'h80, 1'b0, "R10 back to command phase");

        // R7: start sector beyond the end sector, no data
        do_read(8'h00, 8'd2, 8'd0, 8'd5, 8'd1, 8'd3, 1'b0);

        // R5: a single sector at the track end
        do_read(8'h00, 8'd1, 8'd0, 8'd6, 8'd1, 8'd6, 1'b0);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule